// File: doc/BRIEF.md
# I2C Ten-Bit Address Slave Receiver

This block is the receive side of an I2C slave that answers write transfers addressed with a ten-bit address. It watches the bus clock and data lines through a synchroniser and finds Start and Stop conditions. It shifts in each byte on the rising clock edge and either acknowledges the byte or leaves the data line released. It controls the bus only through two pull-low enables, so the pads act as open-drain outputs.

A single host-visible address register serves both halves of the ten-bit address. After the first address byte is acknowledged, an update-address flag goes up and the block holds the clock low. Host firmware then loads the low address byte into the register, which releases the clock. After the low byte, the flag goes up again and firmware restores the high byte. Data bytes then land in a receive buffer. When stretching is enabled, each data byte also clears a clock-release bit and holds the clock until the host sets that bit again.

The state machine has six states. S_IDLE waits for a Start. S_SHIFT takes in eight bits. S_ACK_SETUP waits for the eighth falling edge once the byte is judged. S_ACK_BIT drives or withholds the acknowledge through the ninth clock. S_STRETCH holds the clock low. S_IGNORE sits out a refused transfer.

The transitions are:
- IDLE→SHIFT on Start.
- SHIFT→ACK_SETUP on the eighth rising edge.
- ACK_SETUP→ACK_BIT on the next falling edge.
- ACK_BIT leaves on the ninth falling edge: to IGNORE when the byte is refused, to STRETCH after an address byte or after a data byte with stretching enabled, and otherwise to SHIFT.
- STRETCH→SHIFT when the host clears the update-address flag (address bytes) or sets clock-release (data bytes).
- A Stop from any state goes to IDLE. A Start from any state goes to SHIFT for a new high address byte.

Top module: `tenbit_i2c_rx`

## Requirements
- R1: After reset every status flag is 0, clock-release is 1, the address register and receive buffer are 0, and neither bus line is pulled low.
- R2: A Start (data falling while clock high) sets start_seen and clears stop_seen, and raises irq only when start_irq_en is 1. A Stop (data rising while clock high) sets stop_seen and clears start_seen.
- R3: A first byte whose bits [7:3] are 11110, whose bits [7:1] equal the address register bits [7:1], and whose bit 0 (R/W) is 0 is acknowledged (data pulled low during the ninth clock). After the ninth falling edge, upd_addr and irq are set and the clock is held low.
- R4: While the clock is held after an address byte, it stays low until an accepted host write to the address register, which clears upd_addr and releases the clock.
- R5: The second byte is compared with all 8 bits of the address register. On a match it is acknowledged, upd_addr and irq are set and the clock is held.
- R6: Host writes to the address register are ignored from the eighth rising clock edge of a byte until its ninth falling edge.
- R7: A second byte that does not match is not acknowledged. After its ninth clock irq and upd_addr are set, while buf_full and clk_rel keep their values and the clock is not held. Later bytes are not acknowledged until the next Start.
- R8: A first byte that fails the R3 match (including R/W = 1) is not acknowledged and sets no flag. Bytes are then ignored until the next Start.
- R9: A data byte received with buf_full clear is placed in rx_buf, sets buf_full and is acknowledged, and irq is set after the ninth clock. With stretch_en at 0 the clock is not held.
- R10: With stretch_en at 1, an acknowledged data byte clears clk_rel and holds the clock low until the host pulses clk_rel_wr, which sets clk_rel to 1.
- R11: A host pulse on buf_rd clears buf_full and overflow.
- R12: A data byte that completes while buf_full is 1 is not acknowledged, sets overflow and leaves rx_buf unchanged.
- R13: A Stop returns the receiver to idle, so following bytes are not acknowledged without a new Start. A Start in mid-transfer restarts reception with a high address byte.
- R14: A pulse on irq_clr clears irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| scl_pull | output | 1 | 1 pulls the bus clock low (stretch) |
| sda_pull | output | 1 | 1 pulls the bus data low (acknowledge) |
| stretch_en | input | 1 | Hold the clock after each acknowledged data byte |
| start_irq_en | input | 1 | Raise irq on Start |
| addr_wr | input | 1 | Host write strobe for the address register |
| addr_wdata | input | 8 | Host write value for the address register |
| addr_reg | output | 8 | Current address register |
| buf_rd | input | 1 | Host read strobe of the receive buffer |
| rx_buf | output | 8 | Receive buffer |
| clk_rel_wr | input | 1 | Host writes 1 to clock-release |
| irq_clr | input | 1 | Host clears irq |
| start_seen | output | 1 | Start detected last |
| stop_seen | output | 1 | Stop detected last |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| overflow | output | 1 | A byte arrived while buf_full was set |
| upd_addr | output | 1 | Host must reload the address register |
| clk_rel | output | 1 | Clock-release bit |
| irq | output | 1 | Interrupt flag |

## Verification
A wrong state or byte-kind register shows up at the data line within one bus bit time: an acknowledge is missing or appears where none belongs. A clock left held or released by mistake stalls or speeds up the master's next rising edge. A wrong ack decision or buffer write is visible a few system clocks after the ninth falling edge in upd_addr, irq, buf_full, overflow or rx_buf. An address register that accepts a write during the acknowledge window changes addr_reg on the next clock, and the next address byte is then refused.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SHIFT,
        S_ACK_SETUP,
        S_ACK_BIT,
        S_STRETCH,
        S_IGNORE
    } rx_state_t;

    typedef enum logic [1:0] {
        K_ADDR_HI,
        K_ADDR_LO,
        K_DATA
    } byte_kind_t;

    localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;
endpackage

// File: rtl/i2c10_line_sync.sv
module i2c10_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s && !scl_prev;
    assign scl_fall  = !scl_s && scl_prev;
    assign start_det = scl_s && scl_prev && sda_prev && !sda_s;
    assign stop_det  = scl_s && scl_prev && !sda_prev && sda_s;
endmodule

// File: rtl/i2c10_byte_shift.sv
module i2c10_byte_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         sample,
    input  logic         bit_in,
    output logic         byte_done,
    output logic [W-1:0] byte_val
);
    localparam int CNT_W = $clog2(W);

    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     sh;

    assign byte_val  = {sh[W-2:0], bit_in};
    assign byte_done = en && sample && (cnt == CNT_W'(W-1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && sample) begin
            sh  <= byte_val;
            cnt <= byte_done ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tenbit_i2c_rx.sv
module tenbit_i2c_rx
    import i2c10_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic              stretch_en,
    input  logic              start_irq_en,
    input  logic              addr_wr,
    input  logic [BYTE_W-1:0] addr_wdata,
    output logic [BYTE_W-1:0] addr_reg,
    input  logic              buf_rd,
    output logic [BYTE_W-1:0] rx_buf,
    input  logic              clk_rel_wr,
    input  logic              irq_clr,
    output logic              start_seen,
    output logic              stop_seen,
    output logic              buf_full,
    output logic              overflow,
    output logic              upd_addr,
    output logic              clk_rel,
    output logic              irq
);
    localparam int PFX_W = $bits(TEN_BIT_PREFIX);

    rx_state_t         state, state_nx;
    byte_kind_t        kind, kind_nx;
    logic              ack_ok, ack_ok_nx;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_match;
    logic              ack_end, addr_wr_ok, load_buf, ovf_evt;

    i2c10_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c10_byte_shift #(.W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_det || state != S_SHIFT),
        .en        (state == S_SHIFT),
        .sample    (scl_rise),
        .bit_in    (sda_s),
        .byte_done (byte_done),
        .byte_val  (rx_byte)
    );

    // byte judgement at the eighth rising edge
    always_comb begin
        unique case (kind)
            K_ADDR_HI: byte_match = (rx_byte[BYTE_W-1 -: PFX_W] == TEN_BIT_PREFIX)
                                 && (rx_byte[BYTE_W-1:1] == addr_reg[BYTE_W-1:1])
                                 && !rx_byte[0];
            K_ADDR_LO: byte_match = (rx_byte == addr_reg);
            K_DATA:    byte_match = !buf_full;
            default:   byte_match = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_nx  = state;
        kind_nx   = kind;
        ack_ok_nx = ack_ok;
        unique case (state)
            S_IDLE: ;
            S_SHIFT: begin
                if (byte_done) begin
                    state_nx  = S_ACK_SETUP;
                    ack_ok_nx = byte_match;
                end
            end
            S_ACK_SETUP: begin
                if (scl_fall) state_nx = S_ACK_BIT;
            end
            S_ACK_BIT: begin
                if (scl_fall) begin
                    if (!ack_ok)                       state_nx = S_IGNORE;
                    else if (kind != K_DATA || stretch_en) state_nx = S_STRETCH;
                    else                               state_nx = S_SHIFT;
                end
            end
            S_STRETCH: begin
                if ((kind != K_DATA && !upd_addr) || (kind == K_DATA && clk_rel)) begin
                    state_nx = S_SHIFT;
                    kind_nx  = (kind == K_ADDR_HI) ? K_ADDR_LO : K_DATA;
                end
            end
            S_IGNORE: ;
            default: state_nx = S_IDLE;
        endcase
        if (stop_det) begin
            state_nx = S_IDLE;
        end else if (start_det) begin
            state_nx = S_SHIFT;
            kind_nx  = K_ADDR_HI;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            kind   <= K_ADDR_HI;
            ack_ok <= 1'b0;
        end else begin
            state  <= state_nx;
            kind   <= kind_nx;
            ack_ok <= ack_ok_nx;
        end
    end

    // bus outputs
    always_comb begin
        sda_pull = (state == S_ACK_BIT) && ack_ok;
        scl_pull = (state == S_STRETCH);
    end

    assign ack_end    = (state == S_ACK_BIT) && scl_fall && !start_det && !stop_det;
    assign addr_wr_ok = addr_wr && (state != S_ACK_SETUP) && (state != S_ACK_BIT);
    assign load_buf   = byte_done && (kind == K_DATA) && !buf_full;
    assign ovf_evt    = byte_done && (kind == K_DATA) && buf_full;

    // host-visible registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_reg   <= '0;
            rx_buf     <= '0;
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
            buf_full   <= 1'b0;
            overflow   <= 1'b0;
            upd_addr   <= 1'b0;
            clk_rel    <= 1'b1;
            irq        <= 1'b0;
        end else begin
            if (addr_wr_ok) addr_reg <= addr_wdata;

            if (start_det) begin
                start_seen <= 1'b1;
                stop_seen  <= 1'b0;
            end else if (stop_det) begin
                start_seen <= 1'b0;
                stop_seen  <= 1'b1;
            end

            if (buf_rd) buf_full <= 1'b0;
            if (load_buf) begin
                rx_buf   <= rx_byte;
                buf_full <= 1'b1;
            end

            if (buf_rd)  overflow <= 1'b0;
            if (ovf_evt) overflow <= 1'b1;

            if (addr_wr_ok) upd_addr <= 1'b0;
            if (ack_end && (kind == K_ADDR_LO || (kind == K_ADDR_HI && ack_ok)))
                upd_addr <= 1'b1;

            if (ack_end && ack_ok && kind == K_DATA && stretch_en) clk_rel <= 1'b0;
            else if (clk_rel_wr)                                   clk_rel <= 1'b1;

            if (irq_clr) irq <= 1'b0;
            if ((ack_end && (ack_ok || kind == K_ADDR_LO)) || (start_det && start_irq_en))
                irq <= 1'b1;
        end
    end
endmodule

// File: rtl/i2c10_rx_chk.sv
module i2c10_rx_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_pull,
    input logic              stretch_en,
    input logic              addr_wr,
    input logic [BYTE_W-1:0] addr_reg,
    input logic              buf_rd,
    input logic [BYTE_W-1:0] rx_buf,
    input logic              buf_full,
    input logic              overflow,
    input logic              upd_addr,
    input logic              clk_rel
);
    // R4
    upd_addr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upd_addr) |-> $past(addr_wr));

    // R6
    addr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull && addr_wr) |=> $stable(addr_reg));

    // R10
    clk_rel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_rel) |-> $past(stretch_en));

    // R11
    buf_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && buf_full) |=> !buf_full);

    // R12
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $stable(rx_buf));
endmodule

bind tenbit_i2c_rx i2c10_rx_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_pull   (sda_pull),
    .stretch_en (stretch_en),
    .addr_wr    (addr_wr),
    .addr_reg   (addr_reg),
    .buf_rd     (buf_rd),
    .rx_buf     (rx_buf),
    .buf_full   (buf_full),
    .overflow   (overflow),
    .upd_addr   (upd_addr),
    .clk_rel    (clk_rel)
);

// File: tb/test_tenbit_i2c_rx.sv
`timescale 1ns/1ps
module test_tenbit_i2c_rx;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_pull, sda_pull;
    logic       stretch_en = 1'b0, start_irq_en = 1'b0;
    logic       addr_wr = 1'b0, buf_rd = 1'b0, clk_rel_wr = 1'b0, irq_clr = 1'b0;
    logic [7:0] addr_wdata = '0;
    logic [7:0] addr_reg, rx_buf;
    logic       start_seen, stop_seen, buf_full, overflow, upd_addr, clk_rel, irq;
    logic       scl_bus, sda_bus;
    int         checks = 0, errors = 0;
    logic       done = 1'b0;
    logic       ack;

    always #2.5 clk = ~clk;

    assign scl_bus = scl_m && !scl_pull;
    assign sda_bus = sda_m && !sda_pull;

    tenbit_i2c_rx i_tenbit_i2c_rx (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_pull(scl_pull), .sda_pull(sda_pull),
        .stretch_en(stretch_en), .start_irq_en(start_irq_en),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata), .addr_reg(addr_reg),
        .buf_rd(buf_rd), .rx_buf(rx_buf), .clk_rel_wr(clk_rel_wr), .irq_clr(irq_clr),
        .start_seen(start_seen), .stop_seen(stop_seen), .buf_full(buf_full),
        .overflow(overflow), .upd_addr(upd_addr), .clk_rel(clk_rel), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic host_addr(logic [7:0] v);
        addr_wdata = v; addr_wr = 1'b1; cyc(1); addr_wr = 1'b0; cyc(3);
    endtask

    task automatic host_pulse_rd();
        buf_rd = 1'b1; cyc(1); buf_rd = 1'b0; cyc(2);
    endtask

    task automatic host_irq_clr();
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0; cyc(2);
    endtask

    task automatic host_release();
        clk_rel_wr = 1'b1; cyc(1); clk_rel_wr = 1'b0; cyc(3);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; cyc(Q);
        scl_m = 1'b1; wait_scl_high(); cyc(Q);
        sda_m = 1'b0; cyc(Q);
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; cyc(Q);
        scl_m = 1'b1; wait_scl_high(); cyc(Q);
        sda_m = 1'b1; cyc(Q);
    endtask

    task automatic bus_byte(logic [7:0] b, logic wr_in_ack, logic [7:0] wr_val,
                            output logic got_ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; cyc(Q);
            scl_m = 1'b1; wait_scl_high(); cyc(Q);
            scl_m = 1'b0; cyc(Q);
        end
        sda_m = 1'b1; cyc(Q);
        scl_m = 1'b1; wait_scl_high(); cyc(Q/2);
        got_ack = !sda_bus;
        if (wr_in_ack) begin
            addr_wdata = wr_val; addr_wr = 1'b1; cyc(1); addr_wr = 1'b0;
        end
        cyc(Q/2);
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic t_reset();
        chk("R1 start_seen", start_seen, 0);
        chk("R1 stop_seen", stop_seen, 0);
        chk("R1 buf_full", buf_full, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 upd_addr", upd_addr, 0);
        chk("R1 irq", irq, 0);
        chk("R1 clk_rel", clk_rel, 1);
        chk("R1 addr_reg", addr_reg, 8'h00);
        chk("R1 pulls", {scl_pull, sda_pull}, 2'b00);
    endtask

    task automatic t_basic_receive();
        stretch_en = 1'b0; start_irq_en = 1'b1;
        host_addr(8'hF2);
        bus_start();
        chk("R2 start_seen", start_seen, 1);
        chk("R2 stop_seen", stop_seen, 0);
        chk("R2 irq on start", irq, 1);
        host_irq_clr();
        chk("R14 irq cleared", irq, 0);
        bus_byte(8'hF2, 1'b0, 8'h00, ack);
        chk("R3 high ack", ack, 1);
        chk("R3 upd_addr", upd_addr, 1);
        chk("R3 irq", irq, 1);
        chk("R3 scl held", scl_pull, 1);
        cyc(20);
        chk("R4 still held", scl_pull, 1);
        host_irq_clr();
        host_addr(8'h5A);
        chk("R4 upd_addr cleared", upd_addr, 0);
        chk("R4 scl released", scl_pull, 0);
        bus_byte(8'h5A, 1'b1, 8'h00, ack);
        chk("R5 low ack", ack, 1);
        chk("R6 write in ack ignored", addr_reg, 8'h5A);
        chk("R5 upd_addr", upd_addr, 1);
        chk("R5 irq", irq, 1);
        chk("R5 scl held", scl_pull, 1);
        host_irq_clr();
        host_addr(8'hF2);
        bus_byte(8'h3C, 1'b0, 8'h00, ack);
        chk("R9 data ack", ack, 1);
        chk("R9 buf_full", buf_full, 1);
        chk("R9 rx_buf", rx_buf, 8'h3C);
        chk("R9 irq", irq, 1);
        chk("R9 no stretch", scl_pull, 0);
        chk("R9 clk_rel", clk_rel, 1);
        host_pulse_rd();
        chk("R11 buf_full cleared", buf_full, 0);
        bus_byte(8'hA5, 1'b0, 8'h00, ack);
        chk("R9 second data ack", ack, 1);
        bus_byte(8'h11, 1'b0, 8'h00, ack);
        chk("R12 nack when full", ack, 0);
        chk("R12 overflow", overflow, 1);
        chk("R12 rx_buf kept", rx_buf, 8'hA5);
        host_pulse_rd();
        chk("R11 overflow cleared", overflow, 0);
        chk("R11 buf_full cleared", buf_full, 0);
        bus_stop();
        cyc(4);
        chk("R2 stop_seen", stop_seen, 1);
        chk("R2 start_seen cleared", start_seen, 0);
    endtask

    task automatic t_stretch();
        stretch_en = 1'b1; start_irq_en = 1'b0;
        host_irq_clr();
        bus_start();
        chk("R2 no irq when disabled", irq, 0);
        bus_byte(8'hF2, 1'b0, 8'h00, ack);
        host_addr(8'h5A);
        bus_byte(8'h5A, 1'b0, 8'h00, ack);
        host_addr(8'hF2);
        bus_byte(8'h81, 1'b0, 8'h00, ack);
        chk("R10 data ack", ack, 1);
        chk("R10 clk_rel cleared", clk_rel, 0);
        chk("R10 scl held", scl_pull, 1);
        chk("R10 rx_buf", rx_buf, 8'h81);
        cyc(20);
        chk("R10 still held", scl_pull, 1);
        host_pulse_rd();
        host_release();
        chk("R10 scl released", scl_pull, 0);
        chk("R10 clk_rel set", clk_rel, 1);
        bus_stop();
    endtask

    task automatic t_low_mismatch();
        stretch_en = 1'b1;
        host_irq_clr();
        bus_start();
        bus_byte(8'hF2, 1'b0, 8'h00, ack);
        host_addr(8'h5A);
        host_irq_clr();
        bus_byte(8'h5B, 1'b0, 8'h00, ack);
        chk("R7 low nack", ack, 0);
        chk("R7 irq", irq, 1);
        chk("R7 upd_addr", upd_addr, 1);
        chk("R7 buf_full", buf_full, 0);
        chk("R7 clk_rel unchanged", clk_rel, 1);
        chk("R7 no hold", scl_pull, 0);
        host_addr(8'hF2);
        bus_byte(8'h22, 1'b0, 8'h00, ack);
        chk("R7 later byte nack", ack, 0);
        chk("R7 later byte not stored", buf_full, 0);
        bus_stop();
    endtask

    task automatic t_high_mismatch();
        host_irq_clr();
        bus_start();
        bus_byte(8'hF4, 1'b0, 8'h00, ack);
        chk("R8 high nack", ack, 0);
        chk("R8 no upd_addr", upd_addr, 0);
        chk("R8 no irq", irq, 0);
        bus_byte(8'hF2, 1'b0, 8'h00, ack);
        chk("R8 ignored until start", ack, 0);
        bus_stop();
        bus_start();
        bus_byte(8'hF3, 1'b0, 8'h00, ack);
        chk("R8 read bit refused", ack, 0);
        bus_stop();
    endtask

    task automatic t_restart_stop();
        bus_start();
        bus_byte(8'hF2, 1'b0, 8'h00, ack);
        host_addr(8'h5A);
        host_addr(8'hF2);
        bus_start();
        bus_byte(8'hF2, 1'b0, 8'h00, ack);
        chk("R13 restart high ack", ack, 1);
        host_addr(8'h5A);
        bus_stop();
        bus_byte(8'hF2, 1'b0, 8'h00, ack);
        chk("R13 no ack after stop", ack, 0);
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(3);
        t_reset();
        t_basic_receive();
        t_stretch();
        t_low_mismatch();
        t_high_mismatch();
        t_restart_stop();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule